// File: doc/BRIEF.md
# Load History Table with Offset-Corrected Prefetch

This block keeps a short history of the loads inside each basic block and uses it to issue prefetch addresses ahead of execution. A direct-mapped table is indexed by a basic-block identifier. Each entry holds a tag, a valid bit, an allocation pointer and a small set of load units. Each load unit describes one load: its position in the block, its base register index and its signed displacement. Units are created when loads commit.

On a lookahead pass, the front end names a basic block and a load position. The block reads the execution register file at that unit's base register and keeps the value it reads as the captured value. It then issues a prefetch at captured value + displacement + learned offset. When the same load later commits, the architectural base value is compared with the captured value. The difference becomes the unit's learned offset, so the next prefetch lands closer to the committed address.

The lookahead path is a two-state machine. In `LA_IDLE` it can accept a request. The transition *accept* (a request that hits an entry and a unit) moves it to `LA_READ`. In `LA_READ` the register file is read, and the capture and prefetch are produced. The transition *finish* always returns it to `LA_IDLE`. A request that misses takes the transition *stay* and remains in `LA_IDLE`. The commit port is serviced every cycle without stalling.

Top module: `lht_offset_pf`

## Requirements
- R1: After reset no table entry is valid. `la_ready` is 1, and `pf_valid` and `xrf_rd_en` are 0.
- R2: A commit whose block identifier misses takes over the entry, where a miss means the entry is invalid or its tag differs. The commit clears every unit in that entry and fills one unit with the commit's position, base register and displacement, with a learned offset of zero.
- R3: A lookahead request that hits is accepted in its cycle. In the next cycle `xrf_rd_en` is 1, `xrf_idx` is the unit's base register and `la_ready` is 0. In the cycle after that, `pf_valid` is 1 for exactly one cycle.
- R4: The prefetch address is `xrf_data` + sign-extended 12-bit displacement + learned offset, modulo 2^32.
- R5: A commit that matches a unit holding a captured value sets the unit's offset to `cm_arch_val` minus the captured value. The commit also clears the capture.
- R6: A commit that matches a unit with no captured value leaves the unit's offset unchanged.
- R7: A lookahead that misses produces no register read and no prefetch, and `la_ready` stays 1. A lookahead misses when the entry is invalid, the tag differs, or no valid unit has the requested position.
- R8: A commit with `cm_redef`=1, or with a base register that differs from the unit at that position, allocates a new unit with offset zero. It also retires every older unit at the same position, so at most one valid unit exists per position.
- R9: Units are allocated in round-robin order within an entry. When all 5 units are in use, the oldest allocation is overwritten and its load no longer hits.
- R10: A commit to the same table index during the lookahead read cycle wins. The capture is dropped and no prefetch is issued. A commit to a different index does not disturb the lookahead.
- R11: After an entry is taken over by a block with a different tag, lookahead requests for the previous block miss. Other entries are unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| la_valid | input | 1 | Lookahead request valid |
| la_bbid | input | 8 | Lookahead basic-block identifier (low 3 bits index, rest tag) |
| la_pos | input | 3 | Lookahead load position in the block |
| la_ready | output | 1 | Lookahead port can accept a request |
| xrf_idx | output | 5 | Execution register file read index |
| xrf_rd_en | output | 1 | Execution register file read strobe |
| xrf_data | input | 32 | Execution register file read data (same cycle) |
| cm_valid | input | 1 | Commit update valid |
| cm_bbid | input | 8 | Commit basic-block identifier |
| cm_pos | input | 3 | Commit load position |
| cm_reg | input | 5 | Commit base register index |
| cm_disp | input | 12 | Commit signed displacement |
| cm_redef | input | 1 | Base register was redefined since the unit was filled |
| cm_arch_val | input | 32 | Architectural base register value at commit |
| pf_valid | output | 1 | Prefetch address valid |
| pf_addr | output | 32 | Prefetch address |

## Verification
The bench first drives a negative learned offset and a negative displacement. Both need correct sign handling and wraparound; a design that zero-extended either would miss the expected address by a large power of two. It then sends a second commit with no fresh capture, and one that relearned from a stale capture would change the offset. Next it redefines a register and overfills an entry with six positions; a design that reused the old unit keeps the old offset, and one that did not wrap the allocation pointer still hits the evicted load. It also commits to the same index during the read cycle. A design that let the capture through would emit an unexpected prefetch and learn a nonzero offset on the next commit.

// File: rtl/lht_pkg.sv
package lht_pkg;

    localparam int ADDR_W = 32;
    localparam int REG_W  = 5;
    localparam int DISP_W = 12;
    localparam int POS_W  = 3;

    typedef struct packed {
        logic              vld;
        logic [POS_W-1:0]  pos;
        logic [REG_W-1:0]  rg;
        logic [DISP_W-1:0] disp;
        logic [ADDR_W-1:0] cap;
        logic              cap_vld;
        logic [ADDR_W-1:0] ofs;
    } unit_t;

    typedef enum logic [0:0] {
        LA_IDLE = 1'b0,
        LA_READ = 1'b1
    } la_state_e;

    function automatic unit_t fresh_unit(input logic [POS_W-1:0] pos,
                                         input logic [REG_W-1:0] rg,
                                         input logic [DISP_W-1:0] disp);
        unit_t u;
        u         = '0;
        u.vld     = 1'b1;
        u.pos     = pos;
        u.rg      = rg;
        u.disp    = disp;
        return u;
    endfunction

endpackage

// File: rtl/lht_unit_find.sv
module lht_unit_find #(
    parameter int UNITS = 5
) (
    input  lht_pkg::unit_t [UNITS-1:0]         units_i,
    input  logic [lht_pkg::POS_W-1:0]          pos_i,
    input  logic [lht_pkg::REG_W-1:0]          reg_i,
    input  logic                               need_reg_i,
    output logic [UNITS-1:0]                   match_o
);

    for (genvar u = 0; u < UNITS; u++) begin : g_cmp
        logic pos_eq;
        logic reg_eq;
        assign pos_eq     = (units_i[u].pos == pos_i);
        assign reg_eq     = (units_i[u].rg == reg_i);
        assign match_o[u] = units_i[u].vld && pos_eq && (!need_reg_i || reg_eq);
    end

endmodule

// File: rtl/lht_pf_calc.sv
module lht_pf_calc (
    input  logic [lht_pkg::ADDR_W-1:0] base_i,
    input  logic [lht_pkg::DISP_W-1:0] disp_i,
    input  logic [lht_pkg::ADDR_W-1:0] ofs_i,
    output logic [lht_pkg::ADDR_W-1:0] addr_o
);

    localparam int EXT_W = lht_pkg::ADDR_W - lht_pkg::DISP_W;

    logic [lht_pkg::ADDR_W-1:0] disp_ext;

    assign disp_ext = {{EXT_W{disp_i[lht_pkg::DISP_W-1]}}, disp_i};
    assign addr_o   = base_i + disp_ext + ofs_i;

endmodule

// File: rtl/lht_la_fsm.sv
module lht_la_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic req_i,
    input  logic hit_i,
    output logic ready_o,
    output logic rd_en_o
);

    import lht_pkg::*;

    la_state_e state_q;
    la_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LA_IDLE: if (req_i && hit_i) state_d = LA_READ;
            LA_READ: state_d = LA_IDLE;
            default: state_d = LA_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LA_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        ready_o = 1'b0;
        rd_en_o = 1'b0;
        unique case (state_q)
            LA_IDLE: ready_o = 1'b1;
            LA_READ: rd_en_o = 1'b1;
            default: ready_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/lht_offset_pf.sv
module lht_offset_pf #(
    parameter int ENTRIES = 8,
    parameter int UNITS   = 5,
    parameter int BB_W    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        la_valid,
    input  logic [BB_W-1:0]             la_bbid,
    input  logic [lht_pkg::POS_W-1:0]   la_pos,
    output logic                        la_ready,
    output logic [lht_pkg::REG_W-1:0]   xrf_idx,
    output logic                        xrf_rd_en,
    input  logic [lht_pkg::ADDR_W-1:0]  xrf_data,
    input  logic                        cm_valid,
    input  logic [BB_W-1:0]             cm_bbid,
    input  logic [lht_pkg::POS_W-1:0]   cm_pos,
    input  logic [lht_pkg::REG_W-1:0]   cm_reg,
    input  logic [lht_pkg::DISP_W-1:0]  cm_disp,
    input  logic                        cm_redef,
    input  logic [lht_pkg::ADDR_W-1:0]  cm_arch_val,
    output logic                        pf_valid,
    output logic [lht_pkg::ADDR_W-1:0]  pf_addr
);

    import lht_pkg::*;

    localparam int IDX_W  = $clog2(ENTRIES);
    localparam int TAG_W  = BB_W - IDX_W;
    localparam int UPTR_W = (UNITS > 1) ? $clog2(UNITS) : 1;

    // table storage
    logic                    entry_vld [ENTRIES];
    logic [TAG_W-1:0]        entry_tag [ENTRIES];
    logic [UPTR_W-1:0]       alloc_ptr [ENTRIES];
    unit_t [UNITS-1:0]       tbl_units [ENTRIES];

    function automatic logic [UPTR_W-1:0] first_idx(input logic [UNITS-1:0] v);
        logic [UPTR_W-1:0] r;
        r = '0;
        for (int i = UNITS - 1; i >= 0; i--) begin
            if (v[i]) r = UPTR_W'(i);
        end
        return r;
    endfunction

    // lookahead lookup
    logic [IDX_W-1:0] la_idx;
    logic [TAG_W-1:0] la_tag;
    logic             la_ent_hit;
    logic [UNITS-1:0] la_vec;
    logic             la_hit;

    assign la_idx     = la_bbid[IDX_W-1:0];
    assign la_tag     = la_bbid[BB_W-1:IDX_W];
    assign la_ent_hit = entry_vld[la_idx] && (entry_tag[la_idx] == la_tag);

    lht_unit_find #(.UNITS(UNITS)) u_la_find (
        .units_i    (tbl_units[la_idx]),
        .pos_i      (la_pos),
        .reg_i      ('0),
        .need_reg_i (1'b0),
        .match_o    (la_vec)
    );

    assign la_hit = la_ent_hit && (|la_vec);

    lht_la_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (la_valid),
        .hit_i   (la_hit),
        .ready_o (la_ready),
        .rd_en_o (xrf_rd_en)
    );

    // request held through the read cycle
    logic [IDX_W-1:0]  la_idx_q;
    logic [TAG_W-1:0]  la_tag_q;
    logic [POS_W-1:0]  la_pos_q;
    logic [UPTR_W-1:0] la_unit_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            la_idx_q  <= '0;
            la_tag_q  <= '0;
            la_pos_q  <= '0;
            la_unit_q <= '0;
        end else if (la_valid && la_ready && la_hit) begin
            la_idx_q  <= la_idx;
            la_tag_q  <= la_tag;
            la_pos_q  <= la_pos;
            la_unit_q <= first_idx(la_vec);
        end
    end

    unit_t rd_unit;
    logic  rd_still_ok;
    logic  cm_collide;
    logic  cap_en;

    assign rd_unit     = tbl_units[la_idx_q][la_unit_q];
    assign xrf_idx     = rd_unit.rg;
    assign rd_still_ok = entry_vld[la_idx_q] && (entry_tag[la_idx_q] == la_tag_q)
                         && rd_unit.vld && (rd_unit.pos == la_pos_q);

    // commit lookup
    logic [IDX_W-1:0]  cm_idx;
    logic [TAG_W-1:0]  cm_tag;
    logic              cm_ent_hit;
    logic [UNITS-1:0]  cm_full_vec;
    logic [UNITS-1:0]  cm_pos_vec;
    logic              cm_unit_hit;
    logic [UPTR_W-1:0] cm_unit;
    logic [UPTR_W-1:0] cm_ptr_next;

    assign cm_idx     = cm_bbid[IDX_W-1:0];
    assign cm_tag     = cm_bbid[BB_W-1:IDX_W];
    assign cm_ent_hit = entry_vld[cm_idx] && (entry_tag[cm_idx] == cm_tag);

    lht_unit_find #(.UNITS(UNITS)) u_cm_full (
        .units_i    (tbl_units[cm_idx]),
        .pos_i      (cm_pos),
        .reg_i      (cm_reg),
        .need_reg_i (1'b1),
        .match_o    (cm_full_vec)
    );

    lht_unit_find #(.UNITS(UNITS)) u_cm_pos (
        .units_i    (tbl_units[cm_idx]),
        .pos_i      (cm_pos),
        .reg_i      (cm_reg),
        .need_reg_i (1'b0),
        .match_o    (cm_pos_vec)
    );

    assign cm_unit_hit = (|cm_full_vec) && !cm_redef;
    assign cm_unit     = first_idx(cm_full_vec);
    assign cm_ptr_next = (alloc_ptr[cm_idx] == UPTR_W'(UNITS - 1)) ? '0
                                                                     : alloc_ptr[cm_idx] + 1'b1;

    assign cm_collide = cm_valid && (cm_idx == la_idx_q);
    assign cap_en     = xrf_rd_en && rd_still_ok && !cm_collide;

    // table update: capture first, commit after (commit has priority)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) begin
                entry_vld[e] <= 1'b0;
                entry_tag[e] <= '0;
                alloc_ptr[e] <= '0;
                tbl_units[e] <= '0;
            end
        end else begin
            if (cap_en) begin
                tbl_units[la_idx_q][la_unit_q].cap     <= xrf_data;
                tbl_units[la_idx_q][la_unit_q].cap_vld <= 1'b1;
            end
            if (cm_valid) begin
                if (!cm_ent_hit) begin
                    entry_vld[cm_idx] <= 1'b1;
                    entry_tag[cm_idx] <= cm_tag;
                    tbl_units[cm_idx] <= '0;
                    tbl_units[cm_idx][0] <= fresh_unit(cm_pos, cm_reg, cm_disp);
                    alloc_ptr[cm_idx] <= (UNITS > 1) ? UPTR_W'(1) : '0;
                end else if (cm_unit_hit) begin
                    if (tbl_units[cm_idx][cm_unit].cap_vld) begin
                        tbl_units[cm_idx][cm_unit].ofs <=
                            cm_arch_val - tbl_units[cm_idx][cm_unit].cap;
                        tbl_units[cm_idx][cm_unit].cap_vld <= 1'b0;
                    end
                end else begin
                    for (int u = 0; u < UNITS; u++) begin
                        if (cm_pos_vec[u]) tbl_units[cm_idx][u].vld <= 1'b0;
                    end
                    tbl_units[cm_idx][alloc_ptr[cm_idx]] <= fresh_unit(cm_pos, cm_reg, cm_disp);
                    alloc_ptr[cm_idx] <= cm_ptr_next;
                end
            end
        end
    end

    // prefetch address
    logic [ADDR_W-1:0] calc_addr;

    lht_pf_calc u_calc (
        .base_i (xrf_data),
        .disp_i (rd_unit.disp),
        .ofs_i  (rd_unit.ofs),
        .addr_o (calc_addr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pf_valid <= 1'b0;
            pf_addr  <= '0;
        end else begin
            pf_valid <= cap_en;
            if (cap_en) pf_addr <= calc_addr;
        end
    end

endmodule

// File: rtl/lht_offset_pf_chk.sv
module lht_offset_pf_chk #(
    parameter int IDX_W = 3,
    parameter int UNITS = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             la_valid,
    input logic             la_ready,
    input logic             xrf_rd_en,
    input logic             pf_valid,
    input logic             cm_valid,
    input logic [IDX_W-1:0] cm_idx,
    input logic [IDX_W-1:0] rd_idx,
    input logic [UNITS-1:0] la_vec
);

    // R1
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!pf_valid && !xrf_rd_en));

    // R3
    a_r3_read_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        xrf_rd_en |-> !la_ready);

    // R3
    a_r3_read_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        xrf_rd_en |=> (!xrf_rd_en && la_ready));

    // R3
    a_r3_pf_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> $past(xrf_rd_en));

    // R10
    a_r10_commit_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (xrf_rd_en && cm_valid && (cm_idx == rd_idx)) |=> !pf_valid);

    // R8
    a_r8_one_unit_per_pos: assert property (@(posedge clk) disable iff (!rst_n)
        (la_valid && la_ready) |-> $onehot0(la_vec));

endmodule

bind lht_offset_pf lht_offset_pf_chk #(.IDX_W(IDX_W), .UNITS(UNITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .la_valid  (la_valid),
    .la_ready  (la_ready),
    .xrf_rd_en (xrf_rd_en),
    .pf_valid  (pf_valid),
    .cm_valid  (cm_valid),
    .cm_idx    (cm_idx),
    .rd_idx    (la_idx_q),
    .la_vec    (la_vec)
);

// File: tb/lht_offset_pf_tb.sv
`timescale 1ns/1ps
module lht_offset_pf_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        la_valid = 1'b0;
    logic [7:0]  la_bbid = '0;
    logic [2:0]  la_pos = '0;
    logic        la_ready;
    logic [4:0]  xrf_idx;
    logic        xrf_rd_en;
    logic [31:0] xrf_data = '0;
    logic        cm_valid = 1'b0;
    logic [7:0]  cm_bbid = '0;
    logic [2:0]  cm_pos = '0;
    logic [4:0]  cm_reg = '0;
    logic [11:0] cm_disp = '0;
    logic        cm_redef = 1'b0;
    logic [31:0] cm_arch_val = '0;
    logic        pf_valid;
    logic [31:0] pf_addr;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    string       req_q[$];

    always #2.5 clk = ~clk;

    lht_offset_pf u_dut (
        .clk(clk), .rst_n(rst_n),
        .la_valid(la_valid), .la_bbid(la_bbid), .la_pos(la_pos), .la_ready(la_ready),
        .xrf_idx(xrf_idx), .xrf_rd_en(xrf_rd_en), .xrf_data(xrf_data),
        .cm_valid(cm_valid), .cm_bbid(cm_bbid), .cm_pos(cm_pos), .cm_reg(cm_reg),
        .cm_disp(cm_disp), .cm_redef(cm_redef), .cm_arch_val(cm_arch_val),
        .pf_valid(pf_valid), .pf_addr(pf_addr)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops expected prefetches
    always @(negedge clk) begin
        if (rst_n && pf_valid && !done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7/R10 unexpected prefetch", pf_addr, 32'h0);
            end else begin
                logic [31:0] e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                check(pf_addr == e, r, pf_addr, e);
            end
        end
    end

    task automatic commit(input logic [7:0] bb, input logic [2:0] pos, input logic [4:0] rg,
                          input logic [11:0] disp, input logic redef, input logic [31:0] arch);
        @(negedge clk);
        cm_valid = 1'b1; cm_bbid = bb; cm_pos = pos; cm_reg = rg;
        cm_disp = disp; cm_redef = redef; cm_arch_val = arch;
        @(negedge clk);
        cm_valid = 1'b0; cm_redef = 1'b0;
    endtask

    task automatic lookahead(input logic [7:0] bb, input logic [2:0] pos, input logic [31:0] xval,
                             input bit hit, input logic [4:0] exp_reg, input logic [31:0] exp_addr,
                             input string req);
        @(negedge clk);
        la_valid = 1'b1; la_bbid = bb; la_pos = pos; xrf_data = xval;
        if (hit) begin
            exp_q.push_back(exp_addr);
            req_q.push_back(req);
        end
        @(negedge clk);
        la_valid = 1'b0;
        if (hit) begin
            check(xrf_rd_en && !la_ready, {req, " R3 read cycle"}, {30'd0, xrf_rd_en, la_ready}, 32'h2);
            check(xrf_idx == exp_reg, {req, " R3 read index"}, {27'd0, xrf_idx}, {27'd0, exp_reg});
        end else begin
            check(!xrf_rd_en && la_ready, {req, " R7 miss no read"}, {30'd0, xrf_rd_en, la_ready}, 32'h1);
        end
        @(negedge clk);
    endtask

    task automatic la_with_commit(input logic [7:0] bb, input logic [2:0] pos, input logic [31:0] xval,
                                  input logic [7:0] cbb, input logic [2:0] cpos, input logic [4:0] creg,
                                  input logic [11:0] cdisp, input bit expect_pf,
                                  input logic [31:0] exp_addr, input string req);
        @(negedge clk);
        la_valid = 1'b1; la_bbid = bb; la_pos = pos; xrf_data = xval;
        if (expect_pf) begin
            exp_q.push_back(exp_addr);
            req_q.push_back(req);
        end
        @(negedge clk);
        la_valid = 1'b0;
        cm_valid = 1'b1; cm_bbid = cbb; cm_pos = cpos; cm_reg = creg;
        cm_disp = cdisp; cm_redef = 1'b0; cm_arch_val = 32'h0;
        @(negedge clk);
        cm_valid = 1'b0;
        check(!pf_valid == !expect_pf, {req, " prefetch presence"}, {31'd0, pf_valid}, {31'd0, expect_pf});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(la_ready && !pf_valid && !xrf_rd_en, "R1 reset outputs",
              {29'd0, la_ready, pf_valid, xrf_rd_en}, 32'h4);
        rst_n = 1'b1;
        @(negedge clk);
        check(la_ready && !pf_valid && !xrf_rd_en, "R1 idle after reset",
              {29'd0, la_ready, pf_valid, xrf_rd_en}, 32'h4);
        lookahead(8'h11, 3'd0, 32'h0, 1'b0, 5'd0, 32'h0, "R1 empty table");

        // R2 fill, R4 basic address
        commit(8'h11, 3'd0, 5'd3, 12'h010, 1'b0, 32'h1000);
        lookahead(8'h11, 3'd0, 32'h2000, 1'b1, 5'd3, 32'h2010, "R2 R4 first prefetch");
        lookahead(8'h11, 3'd6, 32'h2000, 1'b0, 5'd0, 32'h0, "R7 absent position");

        // R5 learn positive offset
        commit(8'h11, 3'd0, 5'd3, 12'h010, 1'b0, 32'h2040);
        lookahead(8'h11, 3'd0, 32'h3000, 1'b1, 5'd3, 32'h3050, "R5 positive offset");

        // R5 negative offset, R6 no relearn without capture
        commit(8'h11, 3'd0, 5'd3, 12'h010, 1'b0, 32'h2FF8);
        commit(8'h11, 3'd0, 5'd3, 12'h010, 1'b0, 32'h9999);
        lookahead(8'h11, 3'd0, 32'h5000, 1'b1, 5'd3, 32'h5008, "R5 R6 negative offset kept");

        // R4 negative displacement
        commit(8'h11, 3'd1, 5'd7, 12'hFF0, 1'b0, 32'h0);
        lookahead(8'h11, 3'd1, 32'h100, 1'b1, 5'd7, 32'h0F0, "R4 negative displacement");

        // R8 redefinition and register change
        commit(8'h11, 3'd0, 5'd3, 12'h010, 1'b1, 32'h0);
        lookahead(8'h11, 3'd0, 32'h6000, 1'b1, 5'd3, 32'h6010, "R8 redef offset zero");
        commit(8'h11, 3'd1, 5'd9, 12'h004, 1'b0, 32'h0);
        lookahead(8'h11, 3'd1, 32'h200, 1'b1, 5'd9, 32'h204, "R8 new base register");

        // R9 round robin wrap
        commit(8'h11, 3'd2, 5'd2, 12'h008, 1'b0, 32'h0);
        commit(8'h11, 3'd3, 5'd5, 12'h020, 1'b0, 32'h0);
        commit(8'h11, 3'd4, 5'd4, 12'h000, 1'b0, 32'h0);
        commit(8'h11, 3'd5, 5'd6, 12'h030, 1'b0, 32'h0);
        lookahead(8'h11, 3'd0, 32'h0, 1'b0, 5'd0, 32'h0, "R9 oldest overwritten");
        lookahead(8'h11, 3'd5, 32'h700, 1'b1, 5'd6, 32'h730, "R9 newest unit");
        lookahead(8'h11, 3'd2, 32'h50, 1'b1, 5'd2, 32'h58, "R9 surviving unit");

        // R10 same-index commit wins, capture dropped
        la_with_commit(8'h11, 3'd3, 32'h800, 8'h11, 3'd4, 5'd4, 12'h000, 1'b0, 32'h0, "R10 collision");
        commit(8'h11, 3'd3, 5'd5, 12'h020, 1'b0, 32'h123);
        lookahead(8'h11, 3'd3, 32'h800, 1'b1, 5'd5, 32'h820, "R10 no capture learned");
        la_with_commit(8'h11, 3'd5, 32'h900, 8'h02, 3'd0, 5'd1, 12'h004, 1'b1, 32'h930, "R10 other index");

        // R11 tag replacement
        commit(8'h21, 3'd0, 5'd10, 12'h00C, 1'b0, 32'h0);
        lookahead(8'h11, 3'd2, 32'h0, 1'b0, 5'd0, 32'h0, "R11 old block evicted");
        lookahead(8'h21, 3'd0, 32'hA00, 1'b1, 5'd10, 32'hA0C, "R11 R2 new block");
        lookahead(8'h21, 3'd2, 32'h0, 1'b0, 5'd0, 32'h0, "R2 units cleared");
        lookahead(8'h02, 3'd0, 32'h10, 1'b1, 5'd1, 32'h14, "R11 other entry kept");

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R3 all prefetches issued", exp_q.size(), 32'h0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule